// File: doc/BRIEF.md
# Latency-aware issue interlock

This block sits at the issue stage of an in-order pipeline whose functional units differ in result latency and in how often they accept new work. A decoder presents one instruction at a time: a unit class, a destination register with a write flag, and up to two source registers, each with a use flag. The block issues the instruction in the same cycle if it is safe. Otherwise it raises a stall, and the upstream stage holds the instruction in place. While it waits, the pipeline below receives a bubble.

Two things make it safe to issue. Every source the instruction reads must have its producer's result available. The target unit must also be able to take a new operation. The block tracks a ready countdown for every architectural register and a busy countdown for every functional unit. Issue is strictly in order, so a held instruction blocks everything behind it, including independent work. The register file, operand forwarding, datapaths and branch handling belong to other blocks. This block drives only the issue and stall controls.

Top module: `lat_interlock`

## Requirements
- R1: After reset, all register and unit countdowns are clear, so the first valid instruction issues in the cycle it is presented, whatever it reads.
- R2: With `in_valid` low, `issue` and `stall` are both low. With `in_valid` high, exactly one of them is high in that cycle.
- R3: Unit codes and extra result latencies are 0 = integer (0), 1 = memory (1), 2 = FP add (3), 3 = FP multiply (6) and 4 = FP divide (24). A reader of a register written by an instruction issued in cycle t issues no earlier than cycle t+1+latency. It issues exactly then if nothing else blocks it.
- R4: An integer result may be consumed in the next cycle without a stall. Unit codes 5 to 7 behave as integer.
- R5: Register 0 never causes a dependency stall, and writes to it are ignored.
- R6: A source whose use flag is low never causes a stall.
- R7: The FP divider is not pipelined. After a divide issues in cycle t, no other divide issues before cycle t+24. Other units stay available in the meantime.
- R8: Integer, memory, FP add and FP multiply accept a new operation every cycle.
- R9: A pending result on the second source alone is enough to stall. The stall holds for as long as the same instruction stays presented and the hazard lasts.
- R10: When an instruction writes a register that already has a pending result, the register becomes ready at the later of the two completion times.
- R11: An instruction whose destination write flag is low leaves every register countdown unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| in_valid | input | 1 | A decoded instruction is presented |
| in_unit | input | 3 | Functional unit class code |
| in_dst | input | 5 | Destination register index |
| in_dst_we | input | 1 | Instruction writes its destination |
| in_src1 | input | 5 | First source register index |
| in_src1_used | input | 1 | First source is read |
| in_src2 | input | 5 | Second source register index |
| in_src2_used | input | 1 | Second source is read |
| issue | output | 1 | Presented instruction issues this cycle |
| stall | output | 1 | Presented instruction is held; a bubble goes down the pipe |

## Verification
The bench builds the block with its default parameters: 32 registers and the latency and interval set listed in R3 and R7. These defaults bring the longest waits within reach: the 24-cycle divide result and the 24-cycle divider interval. They also cover a short gap where the integer latency of 0 allows back-to-back use. A behavioural model that keeps absolute ready times per register and per unit predicts `issue` and `stall` in every cycle. This covers the overlap where a divider-busy stall and a register stall coincide, and a write-after-write case where a short-latency write follows a long one.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  localparam int NUM_UNITS = 5;
  localparam int UNIT_W    = 3;

  typedef enum logic [UNIT_W-1:0] {
    U_INT  = 3'd0,
    U_MEM  = 3'd1,
    U_FADD = 3'd2,
    U_FMUL = 3'd3,
    U_FDIV = 3'd4
  } unit_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_bits(input int maxval);
    return (maxval < 1) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/ilk_regtrack.sv
module ilk_regtrack #(
  parameter int NREGS = 32,
  parameter int AW    = 5,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [CW-1:0] wr_lat,
  input  logic [AW-1:0] rd_idx1,
  input  logic [AW-1:0] rd_idx2,
  output logic          rd_pend1,
  output logic          rd_pend2
);
  logic [CW-1:0] cnt_q [NREGS];

  genvar gi;
  generate
    for (gi = 0; gi < NREGS; gi++) begin : g_reg
      if (gi == 0) begin : g_zero
        assign cnt_q[gi] = '0;
      end else begin : g_cnt
        logic          hit;
        logic          en;
        logic [CW-1:0] dec;
        logic [CW-1:0] cnt_d;

        always_comb begin
          hit   = wr_en && (wr_idx == AW'(gi));
          dec   = (cnt_q[gi] != '0) ? cnt_q[gi] - CW'(1) : '0;
          cnt_d = dec;
          if (hit && (wr_lat > dec)) begin
            cnt_d = wr_lat;
          end
          en = hit || (cnt_q[gi] != '0);
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            cnt_q[gi] <= '0;
          end else if (en) begin
            cnt_q[gi] <= cnt_d;
          end
        end

        AST_LAT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en && (wr_idx == AW'(gi))) |=> (cnt_q[gi] >= $past(wr_lat))); // R10
        AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
          (!(wr_en && (wr_idx == AW'(gi))) && (cnt_q[gi] == '0)) |=> (cnt_q[gi] == '0)); // R11
      end
    end
  endgenerate

  assign rd_pend1 = (cnt_q[rd_idx1] != '0);
  assign rd_pend2 = (cnt_q[rd_idx2] != '0);
endmodule

// File: rtl/ilk_unit_busy.sv
module ilk_unit_busy #(
  parameter int II = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic free
);
  localparam int BW = (II > 1) ? $clog2(II) : 1;

  logic [BW-1:0] busy_q;
  logic [BW-1:0] busy_d;
  logic          en;

  always_comb begin
    busy_d = (busy_q != '0) ? busy_q - BW'(1) : '0;
    if (start) begin
      busy_d = BW'(II - 1);
    end
    en = start || (busy_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else if (en) begin
      busy_q <= busy_d;
    end
  end

  assign free = (busy_q == '0);

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !free |-> !start); // R7

  generate
    if (II > 1) begin : g_np
      AST_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !free); // R7
    end else begin : g_pipe
      AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> free); // R8
    end
  endgenerate
endmodule

// File: rtl/lat_interlock.sv
module lat_interlock
  import ilk_pkg::*;
#(
  parameter int NREGS    = 32,
  parameter int LAT_INT  = 0,
  parameter int LAT_MEM  = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_FMUL = 6,
  parameter int LAT_FDIV = 24,
  parameter int II_INT   = 1,
  parameter int II_MEM   = 1,
  parameter int II_FADD  = 1,
  parameter int II_FMUL  = 1,
  parameter int II_FDIV  = 24,
  parameter int AW       = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [UNIT_W-1:0] in_unit,
  input  logic [AW-1:0]     in_dst,
  input  logic              in_dst_we,
  input  logic [AW-1:0]     in_src1,
  input  logic              in_src1_used,
  input  logic [AW-1:0]     in_src2,
  input  logic              in_src2_used,
  output logic              issue,
  output logic              stall
);
  localparam int LMAX = imax(imax(imax(LAT_INT, LAT_MEM), imax(LAT_FADD, LAT_FMUL)), LAT_FDIV);
  localparam int CW   = cnt_bits(LMAX);

  logic [UNIT_W-1:0]    unit_eff;
  logic [CW-1:0]        lat_sel;
  logic [NUM_UNITS-1:0] unit_free;
  logic [NUM_UNITS-1:0] unit_start;
  logic                 free_sel;
  logic                 pend1;
  logic                 pend2;
  logic                 hazard;

  always_comb begin
    unit_eff = (in_unit < UNIT_W'(NUM_UNITS)) ? in_unit : U_INT;
    case (unit_e'(unit_eff))
      U_MEM:   lat_sel = CW'(LAT_MEM);
      U_FADD:  lat_sel = CW'(LAT_FADD);
      U_FMUL:  lat_sel = CW'(LAT_FMUL);
      U_FDIV:  lat_sel = CW'(LAT_FDIV);
      default: lat_sel = CW'(LAT_INT);
    endcase
    free_sel = unit_free[unit_eff];
    hazard   = (in_src1_used && pend1) || (in_src2_used && pend2) || !free_sel;
    issue    = in_valid && !hazard;
    stall    = in_valid && hazard;
  end

  genvar gu;
  generate
    for (gu = 0; gu < NUM_UNITS; gu++) begin : g_unit
      localparam int II_U = (gu == 0) ? II_INT  :
                            (gu == 1) ? II_MEM  :
                            (gu == 2) ? II_FADD :
                            (gu == 3) ? II_FMUL : II_FDIV;
      assign unit_start[gu] = issue && (unit_eff == UNIT_W'(gu));
      ilk_unit_busy #(.II(II_U)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .start(unit_start[gu]),
        .free (unit_free[gu])
      );
    end
  endgenerate

  ilk_regtrack #(.NREGS(NREGS), .AW(AW), .CW(CW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (issue && in_dst_we),
    .wr_idx  (in_dst),
    .wr_lat  (lat_sel),
    .rd_idx1 (in_src1),
    .rd_idx2 (in_src2),
    .rd_pend1(pend1),
    .rd_pend2(pend2)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!issue && !stall)); // R2
  AST_ONE_OF_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (issue != stall)); // R2
  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_src2_used && pend2) |-> stall); // R9
  AST_UNUSED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_src1_used && !in_src2_used && free_sel) |-> issue); // R6
  AST_REG0_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_src1 == '0) && (in_src2 == '0) && free_sel) |-> issue); // R5
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && (in_src1_used && pend1) && $stable(in_src1)) |=> (!in_valid || !$stable(in_src1) || stall || !pend1 || !in_src1_used)); // R9
endmodule

// File: tb/tb_lat_interlock.sv
`timescale 1ns/1ps
module tb_lat_interlock;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [2:0] in_unit;
  logic [4:0] in_dst;
  logic       in_dst_we;
  logic [4:0] in_src1;
  logic       in_src1_used;
  logic [4:0] in_src2;
  logic       in_src2_used;
  logic       issue;
  logic       stall;

  lat_interlock dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_dst_we(in_dst_we), .in_src1(in_src1),
    .in_src1_used(in_src1_used), .in_src2(in_src2), .in_src2_used(in_src2_used),
    .issue(issue), .stall(stall)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rdy   [32];
  int ufree [5];
  int lat_t [5] = '{0, 1, 3, 6, 24};
  int ii_t  [5] = '{1, 1, 1, 1, 24};

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(input string tag, input bit v, input int unit, input int dst, input bit we,
                      input int s1, input bit u1, input int s2, input bit u2, output bit exp_iss);
    int ue;
    bit ok;
    @(negedge clk);
    in_valid = v; in_unit = 3'(unit); in_dst = 5'(dst); in_dst_we = we;
    in_src1 = 5'(s1); in_src1_used = u1; in_src2 = 5'(s2); in_src2_used = u2;
    #1;
    ue = (unit < 5) ? unit : 0;
    ok = (!u1 || s1 == 0 || cyc >= rdy[s1]) && (!u2 || s2 == 0 || cyc >= rdy[s2]) && (cyc >= ufree[ue]);
    exp_iss = v && ok;
    check(tag, issue, exp_iss, "issue");
    check(tag, stall, v && !ok, "stall");
    @(posedge clk);
    if (exp_iss) begin
      if (we && dst != 0 && rdy[dst] < cyc + 1 + lat_t[ue]) rdy[dst] = cyc + 1 + lat_t[ue];
      ufree[ue] = cyc + ii_t[ue];
    end
    cyc++;
  endtask

  task automatic send(input string tag, input int unit, input int dst, input bit we,
                      input int s1, input bit u1, input int s2, input bit u2, output int waited);
    bit iss;
    waited = 0;
    do begin
      step(tag, 1'b1, unit, dst, we, s1, u1, s2, u2, iss);
      if (!iss) waited++;
    end while (!iss && waited < 60);
  endtask

  task automatic idle(input string tag, input int n);
    bit iss;
    for (int k = 0; k < n; k++) step(tag, 1'b0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, iss);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 2000; k++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    int w;
    for (int k = 0; k < 32; k++) rdy[k] = 0;
    for (int k = 0; k < 5; k++) ufree[k] = 0;
    rst_n = 1'b0;
    in_valid = 1'b0; in_unit = '0; in_dst = '0; in_dst_we = 1'b0;
    in_src1 = '0; in_src1_used = 1'b0; in_src2 = '0; in_src2_used = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R2", issue, 1'b0, "issue in reset");
    check("R2", stall, 1'b0, "stall in reset");
    rst_n = 1'b1;
    @(posedge clk);

    // R1: first instruction, a divide, issues at once
    send("R1", 4, 3, 1, 1, 1, 2, 1, w);
    check("R1", w != 0, 1'b0, "first instr waited");
    // R7/R8: multiplier free while divider busy, back-to-back multiplies
    send("R7", 3, 5, 1, 0, 0, 0, 0, w);
    send("R8", 3, 6, 1, 0, 0, 0, 0, w);
    check("R8", w != 0, 1'b0, "back-to-back multiply waited");
    // R3: reader of divide result
    send("R3", 2, 7, 1, 3, 1, 0, 0, w);
    // R7: second divide waits for divider interval
    send("R7", 4, 4, 1, 0, 0, 0, 0, w);
    send("R7", 4, 20, 1, 0, 0, 0, 0, w);
    check("R7", w == 23, 1'b1, "divide interval wait of 23");
    idle("R2", 3);
    // R4: integer result used next cycle; unit code 7 treated as integer
    send("R4", 0, 8, 1, 0, 0, 0, 0, w);
    send("R4", 0, 9, 1, 8, 1, 0, 0, w);
    check("R4", w != 0, 1'b0, "integer dependent waited");
    send("R4", 7, 16, 1, 0, 0, 0, 0, w);
    send("R4", 0, 17, 1, 16, 1, 0, 0, w);
    // R3: memory, add, multiply latencies
    send("R3", 1, 10, 1, 0, 0, 0, 0, w);
    send("R3", 0, 18, 1, 10, 1, 0, 0, w);
    check("R3", w == 1, 1'b1, "memory bubble count");
    send("R3", 2, 11, 1, 0, 0, 0, 0, w);
    send("R3", 0, 18, 1, 11, 1, 0, 0, w);
    check("R3", w == 3, 1'b1, "add bubble count");
    // R9: second source alone stalls
    send("R9", 3, 12, 1, 0, 0, 0, 0, w);
    send("R9", 0, 18, 1, 0, 0, 12, 1, w);
    check("R9", w == 6, 1'b1, "multiply bubble count on src2");
    // R5: writes to register 0 ignored
    send("R5", 3, 0, 1, 0, 0, 0, 0, w);
    send("R5", 0, 19, 1, 0, 1, 0, 1, w);
    check("R5", w != 0, 1'b0, "register 0 stalled");
    // R6: unused source ignored
    send("R6", 3, 13, 1, 0, 0, 0, 0, w);
    send("R6", 0, 19, 1, 13, 0, 13, 0, w);
    check("R6", w != 0, 1'b0, "unused source stalled");
    // R11: no destination write leaves counters untouched
    send("R11", 3, 14, 0, 0, 0, 0, 0, w);
    send("R11", 0, 19, 1, 14, 1, 0, 0, w);
    check("R11", w != 0, 1'b0, "non-writing producer stalled");
    // R10: short write after long write to same register
    idle("R2", 25);
    send("R10", 4, 15, 1, 0, 0, 0, 0, w);
    send("R10", 0, 15, 1, 0, 0, 0, 0, w);
    send("R10", 0, 21, 1, 15, 1, 0, 0, w);
    check("R10", w == 23, 1'b1, "WAW reader waits for later completion");
    idle("R2", 2);
    finish_run();
  end
endmodule